// File: doc/BRIEF.md
# Tagged Branch Target Buffer

This block is a direct-mapped table that the fetch stage consults with nothing more than the current 32-bit program counter. In the same cycle it answers three questions. Is there a remembered taken control transfer at this address? If so, where did it go last time? Was it a plain branch, a call or a return? The fetch unit uses the hit flag to redirect. It uses the target as the next fetch address, and the kind field to push or pop a separate return-address stack. Whether the branch is actually taken this time is left to a separate direction predictor.

The back end writes the table when a control instruction resolves. It supplies the instruction's address, whether it was taken, the real destination and its kind. Only taken outcomes allocate or refresh an entry, so branches that never go the other way never consume space. Entries are selected by the word-address bits just above the byte offset. The remaining upper bits are kept as a tag, so that two addresses sharing a slot are told apart. A newer taken branch that lands on an occupied slot simply evicts the older one.

Top module: `taken_target_cache`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge) every slot is empty, so every lookup misses until a taken update is written.
- R2: A taken update (`upd_en` and `upd_taken` high at a clock edge) stores the tag, target and kind for that address. From the next cycle a lookup of the same address reports a hit with that target and kind.
- R3: An update with `upd_en` high and `upd_taken` low changes nothing: lookups return what they returned before.
- R4: With `upd_en` low nothing is written, whatever the other update inputs carry.
- R5: The slot is chosen by PC bits 9:2 (256 slots). The tag is PC bits 31:10. A lookup whose bits 9:2 select a filled slot but whose bits 31:10 differ from the stored tag misses.
- R6: A taken update to a filled slot replaces its tag, target and kind. The previous address then misses, and the new one hits with the new values.
- R7: Lookup is combinational from `lkp_pc` within the cycle. When an update writes the slot being looked up in the same cycle, the lookup still shows the contents from before that edge.
- R8: On a miss `lkp_target` reads zero and `lkp_kind` reads 0.
- R9: The kind code is 0 for a plain branch, 1 for a call and 2 for a return. It is returned exactly as written.
- R10: PC bits 1:0 take no part in indexing or tag comparison.
- R11: A write to one slot leaves every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties every slot |
| lkp_pc | input | 32 | Fetch address being looked up |
| lkp_hit | output | 1 | A valid slot with a matching tag was found |
| lkp_target | output | 32 | Remembered destination on a hit, zero otherwise |
| lkp_kind | output | 2 | Remembered kind on a hit (0 branch, 1 call, 2 return), zero otherwise |
| upd_en | input | 1 | A resolved control instruction is presented this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_taken | input | 1 | The resolved instruction was taken |
| upd_target | input | 32 | Actual destination of the resolved instruction |
| upd_kind | input | 2 | Kind of the resolved instruction |

## Verification
The bench fills all 256 slots with distinct tags, targets and kinds and reads every one back. A design that indexed with the wrong bits, or let one write spill into another slot, would return a neighbour's target. It then probes aliases that share a slot but differ in the tag bits. A tagless or partly compared design would report a false hit there. Not-taken and disabled updates are applied to filled slots, which catches any design that writes on resolution regardless of outcome. A lookup is issued in the very cycle its slot is rewritten, which separates a design that forwards the new data from one that keeps the old data until the edge. An eviction and a mid-run reset check that stale tags and valid bits really disappear.

// File: rtl/ttc_pkg.sv
package ttc_pkg;

  // Kind of a remembered control transfer
  typedef enum logic [1:0] {
    KIND_JUMP = 2'd0,
    KIND_CALL = 2'd1,
    KIND_RET  = 2'd2,
    KIND_RSVD = 2'd3
  } brkind_e;

  localparam int KIND_W = 2;

endpackage

// File: rtl/ttc_pc_split.sv
// Breaks an address into the slot index and the comparison tag.
module ttc_pc_split #(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 8,
  parameter int TAG_W  = PC_W - IDX_LO - IDX_W
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx,
  output logic [TAG_W-1:0] tag
);

  localparam int IDX_HI = IDX_LO + IDX_W - 1;

  logic unused_offset;

  assign idx = pc[IDX_HI:IDX_LO];
  assign tag = pc[PC_W-1:IDX_HI+1];
  // byte offset within the word is deliberately dropped
  assign unused_offset = ^pc[IDX_LO-1:0];

endmodule

// File: rtl/ttc_valid_bits.sv
// One presence flag per slot; kept in flops so reset can clear all at once.
module ttc_valid_bits #(
  parameter int IDX_W = 8,
  parameter int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_valid
);

  logic [DEPTH-1:0] vld_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else if (set_en) begin
      vld_q[set_idx] <= 1'b1;
    end
  end

  assign rd_valid = vld_q[rd_idx];

endmodule

// File: rtl/ttc_payload_mem.sv
// Tag, target and kind storage; single write port, asynchronous read port
// so it maps onto distributed RAM.
module ttc_payload_mem #(
  parameter int IDX_W  = 8,
  parameter int DATA_W = 56,
  parameter int DEPTH  = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  // read sees the array as it stood before the current edge
  assign rdata = mem[raddr];

endmodule

// File: rtl/ttc_match.sv
// Qualifies a stored slot against the current tag and gates the outputs.
module ttc_match #(
  parameter int PC_W   = 32,
  parameter int TAG_W  = 22,
  parameter int KIND_W = 2
) (
  input  logic              slot_valid,
  input  logic [TAG_W-1:0]  slot_tag,
  input  logic [PC_W-1:0]   slot_target,
  input  logic [KIND_W-1:0] slot_kind,
  input  logic [TAG_W-1:0]  cur_tag,
  output logic              hit,
  output logic [PC_W-1:0]   target,
  output logic [KIND_W-1:0] kind
);

  always_comb begin
    hit    = slot_valid && (slot_tag == cur_tag);
    target = '0;
    kind   = '0;
    if (hit) begin
      target = slot_target;
      kind   = slot_kind;
    end
  end

endmodule

// File: rtl/taken_target_cache.sv
module taken_target_cache #(
  parameter int PC_W   = 32,
  parameter int IDX_LO = 2,
  parameter int IDX_W  = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] lkp_pc,
  output logic        lkp_hit,
  output logic [31:0] lkp_target,
  output logic [1:0]  lkp_kind,
  input  logic        upd_en,
  input  logic [31:0] upd_pc,
  input  logic        upd_taken,
  input  logic [31:0] upd_target,
  input  logic [1:0]  upd_kind
);

  import ttc_pkg::*;

  localparam int TAG_W  = PC_W - IDX_LO - IDX_W;
  localparam int DEPTH  = 1 << IDX_W;
  localparam int DATA_W = TAG_W + PC_W + KIND_W;

  // address decomposition, one per port
  logic [IDX_W-1:0] rd_idx, wr_idx;
  logic [TAG_W-1:0] rd_tag, wr_tag;

  ttc_pc_split #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_rd_split (
    .pc (lkp_pc),
    .idx(rd_idx),
    .tag(rd_tag)
  );

  ttc_pc_split #(.PC_W(PC_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_wr_split (
    .pc (upd_pc),
    .idx(wr_idx),
    .tag(wr_tag)
  );

  // only taken outcomes allocate; reset wins over a concurrent write
  logic alloc;
  assign alloc = upd_en && upd_taken && !rst;

  logic slot_valid;

  ttc_valid_bits #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_valid (
    .clk     (clk),
    .rst     (rst),
    .set_en  (alloc),
    .set_idx (wr_idx),
    .rd_idx  (rd_idx),
    .rd_valid(slot_valid)
  );

  logic [DATA_W-1:0] wr_word, rd_word;
  assign wr_word = {wr_tag, upd_target, upd_kind};

  ttc_payload_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk  (clk),
    .we   (alloc),
    .waddr(wr_idx),
    .wdata(wr_word),
    .raddr(rd_idx),
    .rdata(rd_word)
  );

  logic [TAG_W-1:0]  slot_tag;
  logic [PC_W-1:0]   slot_target;
  logic [KIND_W-1:0] slot_kind;
  assign {slot_tag, slot_target, slot_kind} = rd_word;

  ttc_match #(.PC_W(PC_W), .TAG_W(TAG_W), .KIND_W(KIND_W)) u_match (
    .slot_valid (slot_valid),
    .slot_tag   (slot_tag),
    .slot_target(slot_target),
    .slot_kind  (slot_kind),
    .cur_tag    (rd_tag),
    .hit        (lkp_hit),
    .target     (lkp_target),
    .kind       (lkp_kind)
  );

endmodule

// File: rtl/ttc_checker.sv
module ttc_checker (
  input logic        clk,
  input logic        rst,
  input logic [31:0] lkp_pc,
  input logic        lkp_hit,
  input logic [31:0] lkp_target,
  input logic [1:0]  lkp_kind,
  input logic        upd_en,
  input logic [31:0] upd_pc,
  input logic        upd_taken,
  input logic [31:0] upd_target,
  input logic [1:0]  upd_kind
);

  // R1
  reset_empty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !lkp_hit);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !lkp_hit |-> (lkp_target == 32'd0 && lkp_kind == 2'd0));

  // R2
  alloc_visible_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_en && upd_taken) && lkp_pc == $past(upd_pc))
      |-> (lkp_hit && lkp_target == $past(upd_target) && lkp_kind == $past(upd_kind)));

  // R3
  not_taken_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(upd_en && !upd_taken) && $stable(lkp_pc))
      |-> ($stable(lkp_hit) && $stable(lkp_target) && $stable(lkp_kind)));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(upd_en) && $stable(lkp_pc))
      |-> ($stable(lkp_hit) && $stable(lkp_target) && $stable(lkp_kind)));

endmodule

bind taken_target_cache ttc_checker u_chk (.*);

// File: tb/taken_target_cache_tb.sv
`timescale 1ns/1ps
module taken_target_cache_tb;

  localparam int SLOTS = 256;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] lkp_pc = '0;
  logic        lkp_hit;
  logic [31:0] lkp_target;
  logic [1:0]  lkp_kind;
  logic        upd_en = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [31:0] upd_target = '0;
  logic [1:0]  upd_kind = '0;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // reference model built from the requirements
  bit          m_vld [SLOTS];
  logic [21:0] m_tag [SLOTS];
  logic [31:0] m_tgt [SLOTS];
  logic [1:0]  m_knd [SLOTS];

  always #2 clk = ~clk;

  taken_target_cache u_dut (
    .clk(clk), .rst(rst),
    .lkp_pc(lkp_pc), .lkp_hit(lkp_hit), .lkp_target(lkp_target), .lkp_kind(lkp_kind),
    .upd_en(upd_en), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_kind(upd_kind)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 40000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual cycles=%0d expected < 40000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [31:0] mk_pc(input logic [21:0] tag, input int idx, input int off);
    mk_pc = {tag, idx[7:0], off[1:0]};
  endfunction

  function automatic logic [21:0] tag_of(input int i);
    tag_of = 22'h2B5C3 ^ 22'(i * 977);
  endfunction

  task automatic model_clear();
    for (int i = 0; i < SLOTS; i++) m_vld[i] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
    model_clear();
  endtask

  task automatic apply_upd(input logic en, input logic [31:0] pc, input logic tk,
                           input logic [31:0] tgt, input logic [1:0] kd);
    @(negedge clk);
    upd_en = en; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_kind = kd;
    @(posedge clk);
    #1;
    upd_en = 1'b0;
    if (en && tk) begin
      m_vld[pc[9:2]] = 1'b1;
      m_tag[pc[9:2]] = pc[31:10];
      m_tgt[pc[9:2]] = tgt;
      m_knd[pc[9:2]] = kd;
    end
  endtask

  task automatic check_lkp(input logic [31:0] pc, input string req);
    logic        e_hit;
    logic [31:0] e_tgt;
    logic [1:0]  e_knd;
    int          ix;
    @(negedge clk);
    lkp_pc = pc;
    #1;
    ix = int'(pc[9:2]);
    e_hit = m_vld[ix] && (m_tag[ix] == pc[31:10]);
    e_tgt = e_hit ? m_tgt[ix] : 32'd0;
    e_knd = e_hit ? m_knd[ix] : 2'd0;
    total = total + 1;
    if (lkp_hit !== e_hit || lkp_target !== e_tgt || lkp_kind !== e_knd) begin
      bad = bad + 1;
      $display("FAIL %s pc=%h: actual hit=%b tgt=%h kind=%0d expected hit=%b tgt=%h kind=%0d",
               req, pc, lkp_hit, lkp_target, lkp_kind, e_hit, e_tgt, e_knd);
    end
  endtask

  initial begin
    logic [31:0] old_pc, new_pc;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;

    // R1 / R8: empty after reset, misses read zero
    for (int i = 0; i < SLOTS; i++) check_lkp(mk_pc(tag_of(i), i, 0), "R1_R8");

    // R2 / R9 / R11: fill every slot, kinds cycle 0,1,2
    for (int i = 0; i < SLOTS; i++)
      apply_upd(1'b1, mk_pc(tag_of(i), i, 0), 1'b1, 32'h8000_0000 + 32'(i * 12), 2'(i % 3));
    for (int i = 0; i < SLOTS; i++) check_lkp(mk_pc(tag_of(i), i, 0), "R2_R9_R11");

    // R10: byte offset ignored
    for (int i = 0; i < SLOTS; i += 17) check_lkp(mk_pc(tag_of(i), i, 3), "R10");

    // R5: same slot, different tag bits
    for (int i = 0; i < SLOTS; i += 5) check_lkp(mk_pc(tag_of(i) ^ 22'h200000, i, 0), "R5");
    for (int i = 0; i < SLOTS; i += 11) check_lkp(mk_pc(tag_of(i) ^ 22'h000001, i, 0), "R5");

    // R3: not-taken updates leave slots alone
    apply_upd(1'b1, mk_pc(22'h0FFFF, 5, 0), 1'b0, 32'hDEAD_0000, 2'd1);
    apply_upd(1'b1, mk_pc(tag_of(6), 6, 0), 1'b0, 32'hDEAD_0004, 2'd2);
    check_lkp(mk_pc(tag_of(5), 5, 0), "R3");
    check_lkp(mk_pc(22'h0FFFF, 5, 0), "R3");
    check_lkp(mk_pc(tag_of(6), 6, 0), "R3");

    // R4: disabled update with taken set
    apply_upd(1'b0, mk_pc(22'h1ABCD, 8, 0), 1'b1, 32'hBEEF_0000, 2'd2);
    check_lkp(mk_pc(tag_of(8), 8, 0), "R4");
    check_lkp(mk_pc(22'h1ABCD, 8, 0), "R4");

    // R6: eviction by a different tag
    old_pc = mk_pc(tag_of(7), 7, 0);
    new_pc = mk_pc(22'h3C0DE, 7, 0);
    apply_upd(1'b1, new_pc, 1'b1, 32'h1234_5678, 2'd2);
    check_lkp(old_pc, "R6");
    check_lkp(new_pc, "R6");
    check_lkp(mk_pc(tag_of(6), 6, 0), "R6_R11");
    check_lkp(mk_pc(tag_of(8), 8, 0), "R6_R11");

    // R7: lookup during a write to the same slot shows the old contents
    old_pc = mk_pc(tag_of(9), 9, 0);
    new_pc = mk_pc(22'h15A5A, 9, 0);
    @(negedge clk);
    lkp_pc = old_pc;
    upd_en = 1'b1; upd_pc = new_pc; upd_taken = 1'b1;
    upd_target = 32'hCAFE_F00C; upd_kind = 2'd1;
    #1;
    total = total + 1;
    if (lkp_hit !== 1'b1 || lkp_target !== m_tgt[9] || lkp_kind !== m_knd[9]) begin
      bad = bad + 1;
      $display("FAIL R7 same-cycle: actual hit=%b tgt=%h kind=%0d expected hit=1 tgt=%h kind=%0d",
               lkp_hit, lkp_target, lkp_kind, m_tgt[9], m_knd[9]);
    end
    @(posedge clk);
    #1;
    upd_en = 1'b0;
    m_tag[9] = new_pc[31:10]; m_tgt[9] = 32'hCAFE_F00C; m_knd[9] = 2'd1;
    check_lkp(old_pc, "R7");
    check_lkp(new_pc, "R7");

    // R1: reset in mid-run empties everything
    do_reset();
    for (int i = 0; i < SLOTS; i += 3) check_lkp(mk_pc(tag_of(i), i, 0), "R1");
    check_lkp(new_pc, "R1");

    // R2 after reset: single allocation, call kind
    apply_upd(1'b1, mk_pc(22'h00001, 255, 0), 1'b1, 32'h0000_0100, 2'd1);
    check_lkp(mk_pc(22'h00001, 255, 0), "R2_R9");
    check_lkp(mk_pc(22'h00001, 254, 0), "R11");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule